// File: doc/BRIEF.md
# Serial Flash Quad-Enable Sequencer

This block runs once after reset and makes sure that the quad-enable bit in an external serial flash is set before any execute-in-place reads begin. It drives a single-bit SPI master in mode 0 with 8-bit full-duplex frames. It reads the second status register and compares the value with a target byte. It writes that register only if the value does not match.

When the value matches, the block goes directly to done. When it does not match, the block issues a write-enable in its own chip-select frame. It then sends a status-register-2 write that carries the target byte. After that it keeps reading the first status register until the busy flag clears, or until a poll limit is reached. The serial clock comes from the system clock through an even divider. Returned data is captured one system clock after each rising serial-clock edge.

Top module: `qe_sequencer`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `cs_n` is 1, `sclk` is 0, `done` is 0 and `error` is 0.
- R2: The first chip-select frame is 16 bits long. It sends opcode 0x35 followed by a 0x00 dummy byte. The status value is the byte received during the second byte, and the byte received during the opcode is ignored.
- R3: If that status equals `TARGET` (default 0x02, quad enable is bit 1), `done` rises and no further frame is issued.
- R4: On a mismatch, the next frame is exactly 8 bits carrying opcode 0x06. The frame after it is 16 bits carrying opcode 0x31 and then `TARGET`.
- R5: After the write, 16-bit frames carrying opcode 0x05 and a dummy byte are repeated. The sequence stops at the first one whose second received byte has bit 0 clear, and then `done` rises.
- R6: If `POLL_LIMIT` consecutive polls all report bit 0 set, `error` rises, `done` stays 0 and no further frame is issued.
- R7: The serial clock idles low and has a period of `CLK_DIV` system clocks, high for exactly `CLK_DIV/2`. Bytes go out MSB first, and `mosi` does not change while `sclk` is high.
- R8: `miso` is sampled one system clock after each rising `sclk` edge. A bit that becomes valid just after the rising edge and stays valid for only one system clock is therefore received correctly.
- R9: `cs_n` stays high for at least `CLK_DIV` system clocks between frames, and `sclk` is 0 whenever `cs_n` is high.
- R10: `done` and `error` are never high together, and once either one rises it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| done | output | 1 | Sticky: quad enable confirmed set |
| error | output | 1 | Sticky: busy polling exceeded the limit |

## Verification
A wrong frame-step state shows up at the pins as a frame with the wrong opcode, the wrong length or in the wrong position. The flash model logs every frame, so such a fault is visible when the chip select closes. A fault in the bit counter or the sample point corrupts the status byte, so the decision taken in the next frame is the wrong one: a skipped write, an extra write, or a poll count that does not match. A wrong divider or a short chip-select gap is caught by timing each serial edge and each deselect interval against `CLK_DIV`. A miscounted poll counter shows as `error` rising one poll early or late.

// File: rtl/qe_pkg.sv
`timescale 1ns/1ps
package qe_pkg;
  localparam logic [7:0] OPC_RD_CFG  = 8'h35;
  localparam logic [7:0] OPC_WR_EN   = 8'h06;
  localparam logic [7:0] OPC_WR_CFG  = 8'h31;
  localparam logic [7:0] OPC_RD_STAT = 8'h05;
  localparam logic [7:0] FILL_BYTE   = 8'h00;

  typedef enum logic [2:0] {
    STEP_CHECK, STEP_WEN, STEP_WRITE, STEP_POLL, STEP_DONE, STEP_FAIL
  } step_t;

  typedef enum logic [1:0] {
    XF_GAP, XF_LAUNCH, XF_WAIT, XF_EVAL
  } xfer_t;
endpackage

// File: rtl/qe_clkdiv.sv
`timescale 1ns/1ps
module qe_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/qe_spi_byte.sv
`timescale 1ns/1ps
module qe_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       fin,
  output logic [7:0] rx
);
  logic       active;
  logic       samp_pend;
  logic       tick;
  logic [2:0] bit_idx;
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;

  qe_clkdiv #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      samp_pend <= 1'b0;
      bit_idx   <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      fin       <= 1'b0;
    end else begin
      fin       <= 1'b0;
      samp_pend <= 1'b0;
      // capture one system clock after the rising serial edge
      if (samp_pend) rx_sh <= {rx_sh[6:0], miso};
      if (start && !active) begin
        active  <= 1'b1;
        tx_sh   <= tx;
        mosi    <= tx[7];
        bit_idx <= '0;
        sclk    <= 1'b0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk      <= 1'b1;
          samp_pend <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bit_idx == 3'd7) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            tx_sh   <= {tx_sh[6:0], 1'b0};
            mosi    <= tx_sh[6];
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  assign rx = rx_sh;
endmodule

// File: rtl/qe_sequencer.sv
`timescale 1ns/1ps
module qe_sequencer #(
  parameter int         CLK_DIV    = 4,
  parameter logic [7:0] TARGET     = 8'h02,
  parameter int         POLL_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic cs_n,
  output logic mosi,
  input  logic miso,
  output logic done,
  output logic error
);
  import qe_pkg::*;

  localparam int HALF = CLK_DIV / 2;
  localparam int GAP  = CLK_DIV;
  localparam int GW   = $clog2(GAP + 1);
  localparam int PW   = $clog2(POLL_LIMIT + 1);

  if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_div_check
    $error("CLK_DIV must be a positive even number");
  end

  step_t       step;
  xfer_t       xf;
  logic        byte_idx;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;
  logic [7:0]  status_q;
  logic        b_start;
  logic [7:0]  b_tx;
  logic        b_fin;
  logic [7:0]  b_rx;
  logic [7:0]  op_byte;
  logic [7:0]  arg_byte;
  logic        two_bytes;

  always_comb begin
    op_byte   = OPC_RD_CFG;
    arg_byte  = FILL_BYTE;
    two_bytes = 1'b1;
    case (step)
      STEP_CHECK: op_byte = OPC_RD_CFG;
      STEP_WEN: begin
        op_byte   = OPC_WR_EN;
        two_bytes = 1'b0;
      end
      STEP_WRITE: begin
        op_byte  = OPC_WR_CFG;
        arg_byte = TARGET;
      end
      STEP_POLL: op_byte = OPC_RD_STAT;
      default:   op_byte = OPC_RD_CFG;
    endcase
  end

  qe_spi_byte #(.HALF(HALF)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .start (b_start),
    .tx    (b_tx),
    .miso  (miso),
    .sclk  (sclk),
    .mosi  (mosi),
    .fin   (b_fin),
    .rx    (b_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= STEP_CHECK;
      xf       <= XF_GAP;
      byte_idx <= 1'b0;
      gap_cnt  <= '0;
      poll_cnt <= '0;
      status_q <= '0;
      b_start  <= 1'b0;
      b_tx     <= '0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      b_start <= 1'b0;
      case (xf)
        XF_GAP: begin
          if (step != STEP_DONE && step != STEP_FAIL) begin
            if (gap_cnt == GW'(GAP - 1)) begin
              gap_cnt <= '0;
              xf      <= XF_LAUNCH;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        XF_LAUNCH: begin
          cs_n    <= 1'b0;
          b_start <= 1'b1;
          b_tx    <= byte_idx ? arg_byte : op_byte;
          xf      <= XF_WAIT;
        end
        XF_WAIT: begin
          if (b_fin) begin
            status_q <= b_rx;
            if (!byte_idx && two_bytes) begin
              byte_idx <= 1'b1;
              xf       <= XF_LAUNCH;
            end else begin
              byte_idx <= 1'b0;
              cs_n     <= 1'b1;
              xf       <= XF_EVAL;
            end
          end
        end
        default: begin
          xf <= XF_GAP;
          case (step)
            STEP_CHECK: begin
              if (status_q == TARGET) begin
                step <= STEP_DONE;
                done <= 1'b1;
              end else begin
                step <= STEP_WEN;
              end
            end
            STEP_WEN:   step <= STEP_WRITE;
            STEP_WRITE: begin
              step     <= STEP_POLL;
              poll_cnt <= '0;
            end
            STEP_POLL: begin
              if (!status_q[0]) begin
                step <= STEP_DONE;
                done <= 1'b1;
              end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                step  <= STEP_FAIL;
                error <= 1'b1;
              end else begin
                poll_cnt <= poll_cnt + 1'b1;
              end
            end
            default: step <= step;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/qe_sequencer_chk.sv
`timescale 1ns/1ps
module qe_sequencer_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic done,
  input logic error
);
  localparam int HALF = CLK_DIV / 2;
  int unsigned hi_q;

  always_ff @(posedge clk) begin
    if (rst || !sclk) hi_q <= 0;
    else              hi_q <= hi_q + 1;
  end

  a_r9_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  a_r7_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r7_high_time: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_q == HALF));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (rst)
    error |=> error);
  a_r6_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> cs_n);
endmodule

bind qe_sequencer qe_sequencer_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sclk  (sclk),
  .cs_n  (cs_n),
  .mosi  (mosi),
  .done  (done),
  .error (error)
);

// File: tb/qe_sequencer_test.sv
`timescale 1ns/1ps
module qe_sequencer_test;
  localparam int CLK_DIV    = 4;
  localparam int POLL_LIMIT = 6;
  localparam int TCLK       = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk, cs_n, mosi, done, error;
  logic miso = 1'b0;

  int checks = 0;
  int failures = 0;

  qe_sequencer #(.CLK_DIV(CLK_DIV), .TARGET(8'h02), .POLL_LIMIT(POLL_LIMIT)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .done(done), .error(error)
  );

  always #(TCLK/2) clk = ~clk;

  // flash model state and logs
  logic [7:0]  m_sr2, m_cmd, wr_data;
  logic [15:0] sh;
  int  m_busy_cfg, m_busy_left, bitn, n_frames, n_rd1, bad_wr;
  int  bad_high;
  logic m_wel;
  logic [7:0] f_cmd [0:31];
  int  f_bits [0:31];
  time t_rise, t_cs_rise, min_per, min_gap;
  bit  have_rise, have_cs_rise;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_polls(input int busy);
    return (busy + 1 < POLL_LIMIT) ? busy + 1 : POLL_LIMIT;
  endfunction

  always @(negedge cs_n) begin
    bitn = 0;
    if (have_cs_rise && ($time - t_cs_rise) < min_gap) min_gap = $time - t_cs_rise;
  end

  always @(posedge cs_n) begin
    if (bitn > 0) begin
      if (n_frames < 32) begin
        f_cmd[n_frames]  = m_cmd;
        f_bits[n_frames] = bitn;
      end
      n_frames++;
      if (bitn == 8 && m_cmd == 8'h06) m_wel = 1'b1;
      if (bitn == 16 && m_cmd == 8'h31) begin
        wr_data = sh[7:0];
        if (m_wel) begin
          m_sr2 = sh[7:0];
          m_busy_left = m_busy_cfg;
        end else bad_wr++;
        m_wel = 1'b0;
      end
      if (bitn == 16 && m_cmd == 8'h05) begin
        n_rd1++;
        if (m_busy_left > 0) m_busy_left--;
      end
      t_cs_rise = $time;
      have_cs_rise = 1'b1;
    end
  end

  always @(posedge sclk) begin
    int   i;
    logic b;
    if (have_rise && ($time - t_rise) < min_per) min_per = $time - t_rise;
    t_rise = $time;
    have_rise = 1'b1;
    i = bitn;
    sh = {sh[14:0], mosi};
    bitn++;
    if (bitn == 8) m_cmd = sh[7:0];
    if (i < 8)                  b = 1'($urandom % 2);
    else if (m_cmd == 8'h35)    b = m_sr2[15 - i];
    else if (m_cmd == 8'h05)    b = (i == 15) ? (m_busy_left > 0) : 1'b0;
    else                        b = 1'b0;
    // bit valid for exactly one system clock after the rising edge
    #1 miso = b;
    #(TCLK) miso = ~b;
  end

  always @(negedge sclk) begin
    if (have_rise && ($time - t_rise) != (CLK_DIV / 2) * TCLK) bad_high++;
  end

  task automatic run_case(input logic [7:0] sr2_init, input int busy_cfg);
    bit ended;
    int polls;
    bit exp_err;
    rst = 1'b1;
    m_sr2 = sr2_init; m_busy_cfg = busy_cfg; m_busy_left = 0; m_wel = 1'b0;
    n_frames = 0; n_rd1 = 0; bad_wr = 0; bad_high = 0; bitn = 0; wr_data = 8'h00;
    min_per = 64'd1_000_000_000; min_gap = 64'd1_000_000_000;
    have_rise = 1'b0; have_cs_rise = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 idle pins in reset", {cs_n, sclk}, 2);
    chk(done === 1'b0 && error === 1'b0, "R1 flags in reset", {done, error}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && done === 1'b0 && error === 1'b0, "R1 first cycle after reset",
        {cs_n, done, error}, 4);
    ended = 1'b0;
    for (int c = 0; c < 30000 && !ended; c++) begin
      @(negedge clk);
      if (done || error) ended = 1'b1;
    end
    chk(ended, "R5 R6 case did not finish (watchdog)", ended, 1);
    repeat (300) @(negedge clk);

    chk(f_cmd[0] == 8'h35 && f_bits[0] == 16, "R2 first frame opcode", f_cmd[0], 8'h35);
    chk(done !== error, "R10 exactly one of done/error", {done, error}, 2);
    chk(bad_high == 0 && min_per == CLK_DIV * TCLK, "R7 sclk timing", min_per, CLK_DIV * TCLK);
    if (sr2_init == 8'h02) begin
      chk(n_frames == 1 && done && !error, "R3 R8 match skips programming", n_frames, 1);
    end else begin
      polls   = exp_polls(busy_cfg);
      exp_err = (busy_cfg >= POLL_LIMIT);
      chk(f_cmd[1] == 8'h06 && f_bits[1] == 8, "R4 write-enable frame", f_cmd[1], 8'h06);
      chk(f_cmd[2] == 8'h31 && f_bits[2] == 16 && wr_data == 8'h02 && bad_wr == 0,
          "R4 R7 status write frame", wr_data, 8'h02);
      chk(m_sr2 == 8'h02, "R4 flash register updated", m_sr2, 8'h02);
      chk(n_rd1 == polls && n_frames == 3 + polls, "R5 R8 poll count", n_rd1, polls);
      chk(error == exp_err && done == !exp_err, "R6 outcome", error, exp_err);
      chk(min_gap >= CLK_DIV * TCLK, "R9 deselect gap", min_gap, CLK_DIV * TCLK);
    end
  endtask

  initial begin
    void'($urandom(32'd7341));
    run_case(8'h02, 0);
    run_case(8'h00, 0);
    run_case(8'h00, 3);
    run_case(8'h40, POLL_LIMIT - 1);
    run_case(8'h00, POLL_LIMIT);
    run_case(8'h03, 1000);
    run_case(8'h82, 1);
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      v = ($urandom % 3 == 0) ? 8'h02 : 8'($urandom);
      run_case(v, int'($urandom % 9));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(TCLK * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule